// File: doc/BRIEF.md
# Pad Pull-Resistor Setting Sequencer

This block owns the pull-resistor state of every pad in a bank of general-purpose pins. Software never writes a pin's pull state directly. It first loads one shared 2-bit control code. After a minimum settling time it raises a per-pin strobe bit in one of the strobe-mask words. It then keeps that strobe high for a minimum hold time and finally drops it. Every pin whose strobe rose after a settled code, and stayed high long enough, takes that code as its new pull state. The pads receive each pin's state as a 2-bit code.

The block enforces both timing windows in hardware. A strobe that rises too soon after the control code was written, or that falls too early, leaves the pin as it was. Writing the control code again while a strobe is being held also abandons that pulse. The pull states are write-only from the bus side: every read returns zero.

Top module: `pad_pull_sequencer`

## Requirements
- R1: Reset sets every pin's pull output to the RESET_PULL code, clears all strobe bits and the stored control code, and restarts the settling count. A strobe that rises within SETUP_CYCLES-1 cycles after reset release has no effect.
- R2: A write to byte address 0x94 stores bus_wdata[1:0] as the control code. A committed pin drives that code on pad_pull[2p+1:2p], with 0 = no pull, 1 = pull-down and 2 = pull-up.
- R3: The write at 0x98 holds strobe bits for pins 0..31, with bit j for pin j. The word at 0x9C holds pins 32..53, with bit j for pin 32+j. Its bits 22..31 select no pin and have no effect.
- R4: A strobe rise is accepted only when it falls on a clock edge at least SETUP_CYCLES edges after the last control write. An earlier rise is ignored for the whole of that pulse, however long it is held.
- R5: An accepted rise at edge E makes the new pull state appear at edge E+HOLD_CYCLES, provided the strobe is not cleared before that edge. A strobe cleared earlier leaves the pin's previous state.
- R6: Control code 3 is reserved and is applied as no pull (output 0). The pad outputs never carry code 3.
- R7: Any write to the control register while a strobe is being held cancels that pulse, so the pin keeps its state.
- R8: bus_rdata is always zero. Writes to any address other than the three registers change no pull state.
- R9: Only pins whose strobe bit goes from 0 to 1 start a pulse. Rewriting a 1 onto a bit that is already high starts nothing, and every other pin keeps its state.
- R10: A pull output changes only on the edge that completes a qualified pulse for that pin, and then holds its value until the next qualified pulse or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| pad_pull | output | 2*NUM_PINS | Pull code per pin, pin p at bits [2p+1:2p] |

## Verification
Every result follows a counted number of edges after the stimulus. The bench drives each write half a cycle before edge W. A strobe written SETUP_CYCLES edges after the control write at W is still accepted, and one edge earlier it is not. An accepted pin's output changes exactly HOLD_CYCLES edges after the rise, so the bench samples it on the falling clock half a cycle before that edge and half a cycle after it. Pulses that must not commit are clear-ended and then left idle for more than HOLD_CYCLES before the pads are compared, so a late commit would also be caught. Reset effects are sampled at once, because the reset is asynchronous.

// File: rtl/pullseq_pkg.sv
package pullseq_pkg;

    typedef enum logic [1:0] {
        PULL_OFF  = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_UP   = 2'd2,
        PULL_RSVD = 2'd3
    } pull_e;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned BANK_W = 32;

    // reserved code is applied as no pull
    function automatic logic [1:0] pull_sanitize(input logic [1:0] raw);
        return (raw == PULL_RSVD) ? PULL_OFF : raw;
    endfunction

endpackage

// File: rtl/pullseq_regif.sv
module pullseq_regif
    import pullseq_pkg::*;
#(
    parameter int unsigned NUM_PINS     = 54,
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned CTRL_ADDR    = 'h94,
    parameter int unsigned MASK_BASE    = 'h98,
    parameter int unsigned SETUP_CYCLES = 150
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [1:0]          ctrl_code,
    output logic                ctrl_wr,
    output logic                setup_ok,
    output logic [NUM_PINS-1:0] mask_q,
    output logic [NUM_PINS-1:0] mask_rise
);

    localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int unsigned AGE_W     = $clog2(SETUP_CYCLES + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SETUP_CYCLES);
    localparam logic [AGE_W-1:0] AGE_OK  = AGE_W'(SETUP_CYCLES - 1);

    typedef struct packed {
        logic [1:0]          code;
        logic [AGE_W-1:0]    age;
        logic [NUM_PINS-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;

    logic                 ctrl_hit;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [NUM_PINS-1:0]  mask_next;

    assign ctrl_hit = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_hit[b] = bus_wr && (bus_addr == ADDR_W'(MASK_BASE + 4 * b));
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
        assign mask_next[p] = bank_hit[p / BANK_W] ? bus_wdata[p % BANK_W] : r_q.mask[p];
    end

    always_comb begin
        r_d      = r_q;
        r_d.mask = mask_next;
        if (ctrl_hit) begin
            r_d.code = bus_wdata[1:0];
            r_d.age  = '0;
        end else if (r_q.age < AGE_MAX) begin
            r_d.age = r_q.age + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.code <= PULL_OFF;
            r_q.age  <= '0;
            r_q.mask <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl_code = r_q.code;
    assign ctrl_wr   = ctrl_hit;
    assign setup_ok  = (r_q.age >= AGE_OK);
    assign mask_q    = r_q.mask;
    assign mask_rise = mask_next & ~r_q.mask;

endmodule

// File: rtl/pullseq_pin.sv
module pullseq_pin
    import pullseq_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 150,
    parameter logic [1:0]  RESET_PULL  = 2'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe,
    input  logic       strobe_rise,
    input  logic       ctrl_wr,
    input  logic       setup_ok,
    input  logic [1:0] ctrl_code,
    output logic [1:0] pull
);

    localparam int unsigned HC_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic            armed;
        logic [HC_W-1:0] held;
        logic [1:0]      pull;
    } pin_t;

    pin_t s_d, s_q;
    logic commit;

    assign commit = s_q.armed && strobe && (s_q.held == HC_LAST);

    always_comb begin
        s_d = s_q;
        if (strobe_rise) begin
            s_d.armed = setup_ok;
            s_d.held  = '0;
        end else if (!strobe) begin
            s_d.armed = 1'b0;
            s_d.held  = '0;
        end else begin
            if (s_q.held < HC_LAST) begin
                s_d.held = s_q.held + 1'b1;
            end
            if (commit) begin
                s_d.pull  = pull_sanitize(ctrl_code);
                s_d.armed = 1'b0;
            end else if (ctrl_wr) begin
                s_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.armed <= 1'b0;
            s_q.held  <= '0;
            s_q.pull  <= pull_sanitize(RESET_PULL);
        end else begin
            s_q <= s_d;
        end
    end

    assign pull = s_q.pull;

endmodule

// File: rtl/pad_pull_sequencer.sv
module pad_pull_sequencer
    import pullseq_pkg::*;
#(
    parameter int unsigned NUM_PINS     = 54,
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned CTRL_ADDR    = 'h94,
    parameter int unsigned MASK_BASE    = 'h98,
    parameter int unsigned SETUP_CYCLES = 150,
    parameter int unsigned HOLD_CYCLES  = 150,
    parameter logic [1:0]  RESET_PULL   = 2'd0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic [2*NUM_PINS-1:0] pad_pull
);

    logic [1:0]          ctrl_code;
    logic                ctrl_wr;
    logic                setup_ok;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] mask_rise;

    pullseq_regif #(
        .NUM_PINS    (NUM_PINS),
        .ADDR_W      (ADDR_W),
        .CTRL_ADDR   (CTRL_ADDR),
        .MASK_BASE   (MASK_BASE),
        .SETUP_CYCLES(SETUP_CYCLES)
    ) i_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .ctrl_code(ctrl_code),
        .ctrl_wr  (ctrl_wr),
        .setup_ok (setup_ok),
        .mask_q   (mask_q),
        .mask_rise(mask_rise)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pullseq_pin #(
            .HOLD_CYCLES(HOLD_CYCLES),
            .RESET_PULL (RESET_PULL)
        ) i_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .strobe     (mask_q[p]),
            .strobe_rise(mask_rise[p]),
            .ctrl_wr    (ctrl_wr),
            .setup_ok   (setup_ok),
            .ctrl_code  (ctrl_code),
            .pull       (pad_pull[2*p +: 2])
        );
    end

    // pull states are write-only from the bus
    assign bus_rdata = '0;

endmodule

// File: rtl/pad_pull_sequencer_chk.sv
module pad_pull_sequencer_chk
    import pullseq_pkg::*;
#(
    parameter int unsigned NUM_PINS   = 54,
    parameter logic [1:0]  RESET_PULL = 2'd0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2*NUM_PINS-1:0] pad_pull,
    input logic [1:0]            ctrl_code,
    input logic                  setup_ok,
    input logic [NUM_PINS-1:0]   mask,
    input logic [NUM_PINS-1:0]   mask_rise
);

    localparam logic [1:0] RST_CODE = pull_sanitize(RESET_PULL);
    localparam logic [2*NUM_PINS-1:0] RST_VEC = {NUM_PINS{RST_CODE}};

    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> (pad_pull == RST_VEC));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        a_r10_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(pad_pull[2*i +: 2]) |-> $past(mask[i]));

        a_r2_value_from_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(pad_pull[2*i +: 2]) |-> (pad_pull[2*i +: 2] == pull_sanitize($past(ctrl_code))));

        a_r6_no_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
            pad_pull[2*i +: 2] != PULL_RSVD);

        a_r4_early_rise_inert: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_rise[i] && !setup_ok) |=> $stable(pad_pull[2*i +: 2]));
    end

endmodule

bind pad_pull_sequencer pad_pull_sequencer_chk #(
    .NUM_PINS  (NUM_PINS),
    .RESET_PULL(RESET_PULL)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_pull (pad_pull),
    .ctrl_code(ctrl_code),
    .setup_ok (setup_ok),
    .mask     (mask_q),
    .mask_rise(mask_rise)
);

// File: tb/test_pad_pull_sequencer.sv
module test_pad_pull_sequencer;

    localparam int NPIN  = 54;
    localparam int SETUP = 150;
    localparam int HOLD  = 150;
    localparam logic [7:0] A_CTRL = 8'h94;
    localparam logic [7:0] A_MASK = 8'h98;
    localparam logic [1:0] RSTP   = 2'd1;

    typedef struct packed {
        logic [1:0]  code;
        logic        bank;
        logic [31:0] bits;
        logic [15:0] gap;
        logic [15:0] width;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd2, 1'b0, 32'h0000_000F, 16'd150, 16'd150},  // R2 R4 R5 exact minimums
        '{2'd1, 1'b1, 32'h0030_0001, 16'd200, 16'd160},  // R3 bank 1
        '{2'd2, 1'b0, 32'h0000_00F0, 16'd149, 16'd200},  // R4 setup short by one
        '{2'd2, 1'b0, 32'h0000_0F00, 16'd150, 16'd149},  // R5 hold short by one
        '{2'd3, 1'b0, 32'h0000_0003, 16'd150, 16'd150},  // R6 reserved code
        '{2'd2, 1'b1, 32'hFFFF_FFFF, 16'd300, 16'd150},  // R3 upper bits ignored
        '{2'd0, 1'b1, 32'h0000_0100, 16'd150, 16'd150},  // R2 no pull
        '{2'd1, 1'b0, 32'h8000_0000, 16'd150, 16'd155}   // R3 top bit of bank 0
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [2*NPIN-1:0] pad_pull;

    logic [1:0] expv [NPIN];
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pad_pull_sequencer #(.RESET_PULL(RSTP)) i_pad_pull_sequencer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pad_pull (pad_pull)
    );

    function automatic logic [2*NPIN-1:0] exp_vec();
        logic [2*NPIN-1:0] v;
        for (int p = 0; p < NPIN; p++) v[2*p +: 2] = expv[p];
        return v;
    endfunction

    task automatic check_all(input string req);
        total++;
        if (pad_pull !== exp_vec()) begin
            bad++;
            $display("FAIL %s: pad_pull actual=%h expected=%h", req, pad_pull, exp_vec());
        end
    endtask

    task automatic check_pin(input string req, input int p, input logic [1:0] e);
        total++;
        if (pad_pull[2*p +: 2] !== e) begin
            bad++;
            $display("FAIL %s: pin %0d actual=%0d expected=%0d", req, p, pad_pull[2*p +: 2], e);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        for (int p = 0; p < NPIN; p++) expv[p] = RSTP;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check_all("R1 reset state");

        // table walk
        for (int k = 0; k < 8; k++) begin
            vec_t v;
            logic [7:0] ma;
            v  = VECS[k];
            ma = A_MASK + (v.bank ? 8'd4 : 8'd0);
            bus_write(A_CTRL, {30'b0, v.code});
            idle(int'(v.gap) - 1);
            bus_write(ma, v.bits);
            idle(int'(v.width) - 1);
            bus_write(ma, 32'h0);
            idle(HOLD + 2);
            if (int'(v.gap) >= SETUP && int'(v.width) >= HOLD) begin
                for (int j = 0; j < 32; j++) begin
                    int pin;
                    pin = int'(v.bank) * 32 + j;
                    if (pin < NPIN && v.bits[j]) expv[pin] = (v.code == 2'd3) ? 2'd0 : v.code;
                end
            end
            check_all($sformatf("R2/R3/R4/R5/R6 vector %0d", k));
        end

        // R5: exact commit edge for pin 10
        bus_write(A_CTRL, 32'd2);
        idle(SETUP - 1);
        bus_write(A_MASK, 32'h0000_0400);
        idle(HOLD - 1);
        check_pin("R5 one edge before commit", 10, expv[10]);
        idle(1);
        expv[10] = 2'd2;
        check_pin("R5 at commit edge", 10, 2'd2);
        bus_write(A_MASK, 32'h0);
        check_all("R10 state kept after strobe drop");

        // R7: control rewrite during hold cancels pin 12
        bus_write(A_CTRL, 32'd2);
        idle(SETUP - 1);
        bus_write(A_MASK, 32'h0000_1000);
        idle(20);
        bus_write(A_CTRL, 32'd2);
        idle(HOLD + 20);
        bus_write(A_MASK, 32'h0);
        check_pin("R7 cancelled pulse", 12, expv[12]);

        // R9: bit 14 stays high, bit 15 rises
        bus_write(A_CTRL, 32'd2);
        idle(SETUP - 1);
        bus_write(A_MASK, 32'h0000_4000);
        idle(HOLD);
        expv[14] = 2'd2;
        bus_write(A_CTRL, 32'd0);
        idle(SETUP - 1);
        bus_write(A_MASK, 32'h0000_C000);
        idle(HOLD + 5);
        expv[15] = 2'd0;
        check_pin("R9 held bit not retriggered", 14, 2'd2);
        check_all("R9 only rising bit applied");
        bus_write(A_MASK, 32'h0);

        // R8: stray writes and reads
        bus_write(A_CTRL, 32'd2);
        idle(SETUP + 5);
        bus_write(8'h90, 32'hFFFF_FFFF);
        bus_write(8'hA0, 32'hFFFF_FFFF);
        idle(HOLD + 5);
        check_all("R8 stray writes ignored");
        total++;
        if (bus_rdata !== 32'h0) begin
            bad++;
            $display("FAIL R8: bus_rdata actual=%h expected=%h", bus_rdata, 32'h0);
        end

        // R1: reset mid-run, then an early rise after release
        rst_n = 1'b0;
        #1;
        for (int p = 0; p < NPIN; p++) expv[p] = RSTP;
        check_all("R1 asynchronous reset");
        idle(2);
        rst_n = 1'b1;
        idle(1);
        bus_write(A_MASK, 32'h0010_0000);
        idle(HOLD + 10);
        bus_write(A_MASK, 32'h0);
        check_pin("R1 settle count restarts at reset", 20, RSTP);
        check_all("R1 all pins after reset");

        finish_run();
    end

endmodule